// File: doc/BRIEF.md
# Packed Integer Vector ALU

This block is a lane-parallel integer arithmetic unit for 128-bit vectors. A two-bit select splits each vector into lanes of 8, 16, 32 or 64 bits while the block runs. Every lane then performs the same operation on the matching lanes of two source vectors. The operations are wrapping arithmetic, saturating arithmetic for narrow lanes, shifts by one scalar amount, and ordered or equality comparisons.

Comparisons return one flag per lane, packed into a 16-bit mask. Two flags reduce that mask: one is set when any lane compared true, the other when every lane did. All results are registered, so they appear one clock after the operands are presented. A request that has no meaning raises an error flag and returns zeros: either saturation on wide lanes or an unassigned operation code.

Top module: `simd_int_alu`

## Requirements
- R1: Operation codes 0 (add), 1 (subtract a minus b), 2 (negate a) and 3 (multiply) keep only the low W bits of each lane result. Lane n occupies vector bits n*W to n*W+W-1. Every output is registered and shows the result for the operands sampled at the previous rising clock edge.
- R2: Width select values 0, 1, 2 and 3 give lane widths of 8, 16, 32 and 64 bits, which means 16, 8, 4 and 2 lanes.
- R3: With the signed flag at 1, codes 4 (saturating add) and 5 (saturating subtract) clamp each lane to the range -2^(W-1) to 2^(W-1)-1.
- R4: With the signed flag at 0, codes 4 and 5 clamp each lane to the range 0 to 2^W-1.
- R5: Codes 4 and 5 with a lane width of 32 or 64 set the illegal flag. The vector, the mask and both reduction flags are then zero.
- R6: Code 6 shifts each lane left by the shift input modulo W and ignores the signed flag.
- R7: Code 7 shifts each lane right by the shift input modulo W. The shift is arithmetic when the signed flag is 1 and logical when it is 0.
- R8: Codes 8 (equal) and 9 (not equal) ignore the signed flag. Codes 10 (a<b), 11 (a<=b), 12 (a>b) and 13 (a>=b) compare two's complement values when the signed flag is 1 and unsigned values when it is 0.
- R9: For a comparison, mask bit n holds the result of lane n, mask bits at or above 128/W are zero, and the vector output is zero. For any other operation the mask is zero.
- R10: The any-true flag is set when at least one mask bit is set. The all-true flag is set only for a comparison in which every lane is true.
- R11: Codes 14 and 15 set the illegal flag and return zero on every result output.
- R12: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_a_i | input | 128 | First source vector |
| vec_b_i | input | 128 | Second source vector |
| shamt_i | input | 8 | Scalar shift amount |
| op_i | input | 4 | Operation code |
| signed_i | input | 1 | 1 = two's complement lanes, 0 = unsigned lanes |
| width_i | input | 2 | Lane width select |
| vec_o | output | 128 | Registered vector result |
| lane_mask_o | output | 16 | Registered per-lane comparison mask |
| any_true_o | output | 1 | At least one lane compared true |
| all_true_o | output | 1 | Every lane compared true |
| illegal_o | output | 1 | The request was undefined |

## Verification
The assertions run on every cycle. They check that saturation on wide lanes and the unassigned codes raise the illegal flag with zeroed outputs. They also check that comparisons leave the vector output zero, that no mask bit is set above the active lane count, and that all-true never appears without any-true. Only the bench scenarios can show that the lane values are correct. That covers the saturation clamps at each bound, the shift count taken modulo the lane width, arithmetic versus logical right shifts, and the change of ordered comparisons with the signed flag. The bench compares those against its own lane-by-lane model.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int VEC_W      = 128;
    localparam int MIN_LANE_W = 8;
    localparam int MASK_W     = VEC_W / MIN_LANE_W;
    localparam int NUM_WIDTHS = 4;
    localparam int SAT_MAX_W  = 16;
    localparam int SHAMT_W    = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_NEG  = 4'd2,
        OP_MUL  = 4'd3,
        OP_ADDS = 4'd4,
        OP_SUBS = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_EQ   = 4'd8,
        OP_NE   = 4'd9,
        OP_LT   = 4'd10,
        OP_LE   = 4'd11,
        OP_GT   = 4'd12,
        OP_GE   = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [MASK_W-1:0] mask;
        logic              any_true;
        logic              all_true;
        logic              illegal;
    } alu_out_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0]  a_i,
    input  logic [LANE_W-1:0]  b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  alu_op_e            op_i,
    input  logic               signed_i,
    output logic [LANE_W-1:0]  res_o,
    output logic               hit_o
);

    localparam int SH_W = $clog2(LANE_W);

    logic [SH_W-1:0]   amt;
    logic [LANE_W-1:0] sat_add;
    logic [LANE_W-1:0] sat_sub;
    logic [LANE_W-1:0] sra_res;
    logic              lt_res;
    logic              eq_res;

    // The lane width is a power of two, so its low bits are the count modulo W
    assign amt = shamt_i[SH_W-1:0];

    generate
        if (LANE_W <= SAT_MAX_W) begin : g_sat
            localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
            localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
            logic [LANE_W:0] ext_a;
            logic [LANE_W:0] ext_b;
            logic [LANE_W:0] sum_x;
            logic [LANE_W:0] dif_x;
            always_comb begin
                ext_a = {signed_i & a_i[LANE_W-1], a_i};
                ext_b = {signed_i & b_i[LANE_W-1], b_i};
                sum_x = ext_a + ext_b;
                dif_x = ext_a - ext_b;
                if (signed_i) begin
                    if (sum_x[LANE_W] != sum_x[LANE_W-1])
                        sat_add = sum_x[LANE_W] ? SMIN : SMAX;
                    else
                        sat_add = sum_x[LANE_W-1:0];
                    if (dif_x[LANE_W] != dif_x[LANE_W-1])
                        sat_sub = dif_x[LANE_W] ? SMIN : SMAX;
                    else
                        sat_sub = dif_x[LANE_W-1:0];
                end else begin
                    sat_add = sum_x[LANE_W] ? {LANE_W{1'b1}} : sum_x[LANE_W-1:0];
                    sat_sub = dif_x[LANE_W] ? '0 : dif_x[LANE_W-1:0];
                end
            end
        end else begin : g_no_sat
            assign sat_add = '0;
            assign sat_sub = '0;
        end
    endgenerate

    always_comb begin
        sra_res = $unsigned($signed(a_i) >>> amt);
        eq_res  = (a_i == b_i);
        lt_res  = signed_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
    end

    always_comb begin
        res_o = '0;
        hit_o = 1'b0;
        case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_NEG:  res_o = '0 - a_i;
            OP_MUL:  res_o = a_i * b_i;
            OP_ADDS: res_o = sat_add;
            OP_SUBS: res_o = sat_sub;
            OP_SHL:  res_o = a_i << amt;
            OP_SHR:  res_o = signed_i ? sra_res : (a_i >> amt);
            OP_EQ:   hit_o = eq_res;
            OP_NE:   hit_o = !eq_res;
            OP_LT:   hit_o = lt_res;
            OP_LE:   hit_o = lt_res | eq_res;
            OP_GT:   hit_o = !(lt_res | eq_res);
            OP_GE:   hit_o = !lt_res;
            default: begin
                res_o = '0;
                hit_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice
    import simd_alu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0]   a_i,
    input  logic [VEC_W-1:0]   b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  alu_op_e            op_i,
    input  logic               signed_i,
    output logic [VEC_W-1:0]   res_o,
    output logic [MASK_W-1:0]  mask_o
);

    localparam int LANES = VEC_W / LANE_W;

    logic [LANES-1:0] hits;

    generate
        for (genvar n = 0; n < LANES; n++) begin : g_lane
            simd_lane #(.LANE_W(LANE_W)) u_lane (
                .a_i      (a_i[n*LANE_W +: LANE_W]),
                .b_i      (b_i[n*LANE_W +: LANE_W]),
                .shamt_i  (shamt_i),
                .op_i     (op_i),
                .signed_i (signed_i),
                .res_o    (res_o[n*LANE_W +: LANE_W]),
                .hit_o    (hits[n])
            );
        end
    endgenerate

    // Unused upper mask bits read as zero
    assign mask_o = MASK_W'(hits);

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
    import simd_alu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [127:0]       vec_a_i,
    input  logic [127:0]       vec_b_i,
    input  logic [7:0]         shamt_i,
    input  logic [3:0]         op_i,
    input  logic               signed_i,
    input  logic [1:0]         width_i,
    output logic [127:0]       vec_o,
    output logic [15:0]        lane_mask_o,
    output logic               any_true_o,
    output logic               all_true_o,
    output logic               illegal_o
);

    logic [VEC_W-1:0]  slice_res  [NUM_WIDTHS];
    logic [MASK_W-1:0] slice_mask [NUM_WIDTHS];
    alu_op_e           op;
    alu_out_t          out_d;
    alu_out_t          out_q;

    assign op = alu_op_e'(op_i);

    generate
        for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
            simd_width_slice #(.LANE_W(MIN_LANE_W << k)) u_slice (
                .a_i      (vec_a_i),
                .b_i      (vec_b_i),
                .shamt_i  (shamt_i),
                .op_i     (op),
                .signed_i (signed_i),
                .res_o    (slice_res[k]),
                .mask_o   (slice_mask[k])
            );
        end
    endgenerate

    logic              is_sat;
    logic              is_cmp;
    logic              is_undef;
    logic              sat_ok;
    logic [MASK_W:0]   full_ext;
    logic [MASK_W-1:0] full_mask;

    always_comb begin
        is_sat    = (op_i == OP_ADDS) || (op_i == OP_SUBS);
        is_cmp    = (op_i >= OP_EQ) && (op_i <= OP_GE);
        is_undef  = (op_i > OP_GE);
        sat_ok    = ((MIN_LANE_W << width_i) <= SAT_MAX_W);
        full_ext  = ((MASK_W+1)'(1) << (MASK_W >> width_i)) - (MASK_W+1)'(1);
        full_mask = full_ext[MASK_W-1:0];

        out_d         = '0;
        out_d.illegal = is_undef || (is_sat && !sat_ok);
        if (!out_d.illegal) begin
            if (is_cmp) begin
                out_d.mask     = slice_mask[width_i];
                out_d.any_true = |slice_mask[width_i];
                out_d.all_true = (slice_mask[width_i] == full_mask);
            end else begin
                out_d.vec = slice_res[width_i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign vec_o       = out_q.vec;
    assign lane_mask_o = out_q.mask;
    assign any_true_o  = out_q.any_true;
    assign all_true_o  = out_q.all_true;
    assign illegal_o   = out_q.illegal;

    // R5
    sat_wide_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past((op_i == OP_ADDS || op_i == OP_SUBS) && width_i[1])
        |-> (illegal_o && vec_o == '0 && lane_mask_o == '0));

    // R11
    undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_i > OP_GE) |-> (illegal_o && vec_o == '0 && !any_true_o));

    // R9
    cmp_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_i >= OP_EQ && op_i <= OP_GE) |-> (vec_o == '0));

    // R9
    mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask_o >> (MASK_W >> $past(width_i))) == '0);

    // R10
    all_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_true_o |-> any_true_o);

    // R9
    noncmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_i < OP_EQ) |-> (lane_mask_o == '0 && !all_true_o));

endmodule

// File: tb/simd_int_alu_tb.sv
module simd_int_alu_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] a = '0, b = '0;
    logic [7:0]   sh = '0;
    logic [3:0]   op = '0;
    logic         sg = 1'b0;
    logic [1:0]   ws = '0;
    logic [127:0] vec_o;
    logic [15:0]  mask_o;
    logic         any_o, all_o, ill_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    simd_int_alu u_dut (
        .clk(clk), .rst_n(rst_n), .vec_a_i(a), .vec_b_i(b), .shamt_i(sh),
        .op_i(op), .signed_i(sg), .width_i(ws), .vec_o(vec_o),
        .lane_mask_o(mask_o), .any_true_o(any_o), .all_true_o(all_o),
        .illegal_o(ill_o)
    );

    function automatic void model(input logic [127:0] va, vb, input logic [7:0] s,
                                  input int o, input bit sgn, input int w_sel,
                                  output logic [127:0] r, output logic [15:0] m,
                                  output bit an, output bit al, output bit il);
        int W = 8 << w_sel;
        int lanes = 128 / W;
        int amt = s % W;
        logic [63:0] lm = (W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << W) - 64'd1);
        logic [16:0] full = (17'd1 << lanes) - 17'd1;
        r = '0; m = '0; an = 0; al = 0;
        il = (o > 13) || ((o == 4 || o == 5) && W > 16);
        if (il) return;
        for (int i = 0; i < lanes; i++) begin
            logic [63:0] x = 64'(va >> (i*W)) & lm;
            logic [63:0] y = 64'(vb >> (i*W)) & lm;
            longint xs = (W < 64 && x[W-1]) ? longint'(x | ~lm) : longint'(x);
            longint ys = (W < 64 && y[W-1]) ? longint'(y | ~lm) : longint'(y);
            longint hi = sgn ? ((64'sd1 <<< (W-1)) - 1) : ((64'sd1 <<< W) - 1);
            longint lo = sgn ? -(64'sd1 <<< (W-1)) : 0;
            longint t;
            logic [63:0] z = '0;
            bit lt = sgn ? (xs < ys) : (x < y);
            bit eq = (x == y);
            bit h = 0;
            case (o)
                0: z = x + y;
                1: z = x - y;
                2: z = 64'd0 - x;
                3: z = x * y;
                4, 5: begin
                    if (sgn) t = (o == 4) ? xs + ys : xs - ys;
                    else     t = (o == 4) ? longint'(x) + longint'(y) : longint'(x) - longint'(y);
                    if (t > hi) t = hi;
                    if (t < lo) t = lo;
                    z = 64'(t);
                end
                6: z = x << amt;
                7: z = sgn ? 64'(xs >>> amt) : (x >> amt);
                8: h = eq;
                9: h = !eq;
                10: h = lt;
                11: h = lt || eq;
                12: h = !(lt || eq);
                default: h = !lt;
            endcase
            r = r | (128'(z & lm) << (i*W));
            m[i] = h;
        end
        an = |m;
        al = (o >= 8) && (m == full[15:0]);
    endfunction

    function automatic string op_tag(input int o, input bit sgn, input int w_sel);
        if (o <= 3) return "R1";
        if (o <= 5) return (w_sel >= 2) ? "R5" : (sgn ? "R3" : "R4");
        if (o == 6) return "R6";
        if (o == 7) return "R7";
        if (o <= 13) return "R8";
        return "R11";
    endfunction

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive on a falling edge; the result is registered on the next rising edge
    task automatic run(input logic [127:0] va, vb, input logic [7:0] s,
                       input int o, input bit sgn, input int w_sel);
        logic [127:0] er; logic [15:0] em; bit ea, el, ei;
        @(negedge clk);
        a = va; b = vb; sh = s; op = 4'(o); sg = sgn; ws = 2'(w_sel);
        model(va, vb, s, o, sgn, w_sel, er, em, ea, el, ei);
        @(negedge clk);
        chk(op_tag(o, sgn, w_sel), vec_o, er);
        chk("R9", 128'(mask_o), 128'(em));
        chk("R10", {126'd0, any_o, all_o}, {126'd0, ea, el});
        chk((o > 13) ? "R11" : "R5", 128'(ill_o), 128'(ei));
    endtask

    function automatic logic [127:0] rep8(input logic [7:0] v);
        return {16{v}};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R12: outputs zero during reset
        chk("R12", {vec_o, mask_o, any_o, all_o, ill_o} == '0 ? 128'd0 : 128'd1, 128'd0);
        rst_n = 1'b1;

        run(rep8(8'hFF), rep8(8'h01), 0, 0, 0, 0);          // R1 wrap add
        run({8{16'h8000}}, {8{16'h0002}}, 0, 3, 0, 1);      // R1, R2 wrap mul 16-bit
        run(rep8(8'h7F), rep8(8'h01), 0, 4, 1, 0);          // R3 signed max clamp
        run(rep8(8'h80), rep8(8'h01), 0, 5, 1, 0);          // R3 signed min clamp
        run({8{16'h7FF0}}, {8{16'h0100}}, 0, 4, 1, 1);      // R3 16-bit clamp
        run(rep8(8'hFF), rep8(8'h01), 0, 4, 0, 0);          // R4 unsigned max clamp
        run(rep8(8'h00), rep8(8'h01), 0, 5, 0, 0);          // R4 unsigned floor
        run(rep8(8'h7F), rep8(8'h01), 0, 4, 1, 2);          // R5 illegal 32-bit saturation
        run(rep8(8'h81), '0, 8'd9, 6, 1, 0);                // R6 shift by 9 mod 8 = 1
        run(rep8(8'h80), '0, 8'd1, 7, 1, 0);                // R7 arithmetic right shift
        run(rep8(8'h80), '0, 8'd65, 7, 0, 3);               // R7 logical, count mod 64
        run(rep8(8'h80), rep8(8'h01), 0, 10, 1, 0);         // R8 signed less-than
        run(rep8(8'h80), rep8(8'h01), 0, 10, 0, 0);         // R8 unsigned less-than
        run(rep8(8'h5A), rep8(8'h5A), 0, 8, 0, 3);          // R9, R10 64-bit all-true
        run(rep8(8'h11), rep8(8'h22), 0, 14, 0, 0);         // R11 undefined code

        for (int k = 0; k < 1500; k++) begin
            logic [127:0] va = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] vb = {$urandom, $urandom, $urandom, $urandom};
            int sel = $urandom_range(0, 3);
            if (sel == 0) vb = va;
            if (sel == 1) begin
                for (int j = 0; j < 16; j++) begin
                    logic [7:0] pick [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
                    va[j*8 +: 8] = pick[$urandom_range(0, 3)];
                    vb[j*8 +: 8] = pick[$urandom_range(0, 3)];
                end
            end
            run(va, vb, 8'($urandom), $urandom_range(0, 15), 1'($urandom), $urandom_range(0, 3));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule